// File: doc/BRIEF.md
# Sparse Subtensor Read Command Generator

This block converts a request for a rectangular window of a compressed feature map into a stream of DRAM burst read commands. The map is stored as 8x8-position by 8-channel blocks. Each block is cut at one configurable split point per axis, so it holds four subtensors of unequal shape. Each subtensor is compressed on its own and stored right after the previous one. A per-block metadata word gives the block's base pointer and the compressed size of each of its four subtensors. The block reads that word for every block the window touches. It then emits an (address, length) command for each subtensor that lies inside the window and is not all zero.

A window is legal only when each of its edges falls on a block edge or on the split point. The window is then covered by whole subtensors and nothing is fetched in part. An illegal request raises an error pulse and starts no work. The block takes one window at a time. It signals the end of a window with a done pulse, which accompanies the final command.

Top module: `gt_fetch_agen`

## Requirements
- R1: After reset `req_ready` is 1, and `cmd_valid`, `win_done`, `req_err` and `meta_rd_en` are 0.
- R2: For each block the window touches, in raster order, the block asserts `meta_rd_en` for one cycle with `meta_rd_addr = (grp*MAP_BH + block_row)*MAP_BW + block_col`, where block_row = y>>3 and block_col = x>>3. It uses `meta_rd_data` one cycle later.
- R3: Exactly the subtensors that overlap the window `[x0..x1] x [y0..y1]` (inclusive) and have a nonzero size get a command. The left columns of a block are local 0..split_x-1 and the right columns are split_x..7. The top rows are local 0..split_y-1 and the bottom rows are split_y..7.
- R4: A subtensor whose size field is 0 produces no command, and `cmd_len` is never 0.
- R5: Metadata bits [47:20] hold the word pointer. Bits [5q+4:5q] hold the size of subtensor q, counted in 16-word bursts, with q = 0 top-left, 1 top-right, 2 bottom-left and 3 bottom-right. A command has `cmd_len` = size(q) and `cmd_addr` = pointer + 16 x the sum of the sizes of subtensors 0..q-1 (modulo 2^28).
- R6: Commands come out in order of block row, then block column, then q.
- R7: `win_done` is high together with the window's final command. If a window yields no command, `win_done` pulses alone for one cycle with `cmd_valid` low.
- R8: A request is rejected when any of the following holds: x0 mod 8 or y0 mod 8 is neither 0 nor the split; (x1+1) mod 8 or (y1+1) mod 8 is neither 0 nor the split; x0>x1; y0>y1; or grp >= GROUPS. A rejected request sets `req_err` for the one cycle after acceptance, issues no metadata read and no command, and leaves `req_ready` at 1.
- R9: After a legal request is accepted, `req_ready` stays 0 until the final command has been taken (or the lone done pulse has been given).
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_addr`, `cmd_len` and `win_done` hold their values.
- R11: `cmd_valid` is 0 in the cycle that issues a metadata read and in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_x | input | 3 | Column split point inside a block (1..7), held while busy |
| split_y | input | 3 | Row split point inside a block (1..7), held while busy |
| req_valid | input | 1 | Window request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_x0 | input | XW | First column of the window |
| req_y0 | input | YW | First row of the window |
| req_x1 | input | XW | Last column of the window (inclusive) |
| req_y1 | input | YW | Last row of the window (inclusive) |
| req_grp | input | GW | Channel group |
| req_err | output | 1 | One-cycle pulse: request rejected |
| meta_rd_en | output | 1 | Metadata read strobe |
| meta_rd_addr | output | MAW | Metadata block index |
| meta_rd_data | input | 48 | Metadata word, valid one cycle after the strobe |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Read command taken |
| cmd_addr | output | 28 | Command start word address |
| cmd_len | output | 5 | Command length in 16-word bursts |
| win_done | output | 1 | Final command of the window, or lone end pulse |

## Verification
Some properties are checked on every cycle. These are: a held command stays stable under backpressure, no command is shown while a metadata read is in flight, no zero-length command appears, the error pulse coincides with an idle block, and a request cannot be taken while a command is shown. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model. This covers which subtensors get covered for a given split, the offset sums, raster order, the skipping of empty subtensors, done timing when the trailing blocks are all zero, and the rejection rules.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int LOC_W    = 3;
    localparam int PTR_W    = 28;
    localparam int SZ_W     = 5;
    localparam int NQ       = 4;
    localparam int META_W   = PTR_W + NQ * SZ_W;
    localparam int BURST_LG = 4;
    localparam int PRE_W    = SZ_W + 2;

    typedef struct packed {
        logic [PTR_W-1:0]         ptr;
        logic [NQ-1:0][SZ_W-1:0]  sz;
    } blk_meta_t;

    typedef struct packed {
        logic [PTR_W-1:0] addr;
        logic [SZ_W-1:0]  len;
    } rd_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_META,
        ST_LOAD,
        ST_SCAN,
        ST_FLUSH
    } seq_st_e;

    function automatic logic start_on_edge(logic [LOC_W-1:0] lo, logic [LOC_W-1:0] split);
        return (lo == '0) || (lo == split);
    endfunction

    function automatic logic end_on_edge(logic [LOC_W-1:0] lo, logic [LOC_W-1:0] split);
        logic [LOC_W-1:0] nxt;
        nxt = lo + 1'b1;
        return (nxt == '0) || (nxt == split);
    endfunction
endpackage

// File: rtl/gt_req_check.sv
module gt_req_check
    import gt_pkg::*;
#(
    parameter int XW     = 5,
    parameter int YW     = 5,
    parameter int GW     = 2,
    parameter int GROUPS = 3
) (
    input  logic [XW-1:0]    x0,
    input  logic [YW-1:0]    y0,
    input  logic [XW-1:0]    x1,
    input  logic [YW-1:0]    y1,
    input  logic [GW-1:0]    grp,
    input  logic [LOC_W-1:0] split_x,
    input  logic [LOC_W-1:0] split_y,
    output logic             legal
);
    logic edges_ok, order_ok, grp_ok;

    always_comb begin
        edges_ok = start_on_edge(x0[LOC_W-1:0], split_x) && end_on_edge(x1[LOC_W-1:0], split_x)
                && start_on_edge(y0[LOC_W-1:0], split_y) && end_on_edge(y1[LOC_W-1:0], split_y);
        order_ok = (x0 <= x1) && (y0 <= y1);
        grp_ok   = (32'(grp) < 32'(GROUPS));
        legal    = edges_ok && order_ok && grp_ok;
    end
endmodule

// File: rtl/gt_quad_map.sv
module gt_quad_map
    import gt_pkg::*;
#(
    parameter int XW = 5,
    parameter int YW = 5
) (
    input  logic [XW-LOC_W-1:0] bx,
    input  logic [YW-LOC_W-1:0] by,
    input  logic [XW-1:0]       wx0,
    input  logic [XW-1:0]       wx1,
    input  logic [YW-1:0]       wy0,
    input  logic [YW-1:0]       wy1,
    input  logic [LOC_W-1:0]    split_x,
    input  logic [LOC_W-1:0]    split_y,
    input  blk_meta_t           meta,
    output logic [NQ-1:0]       want,
    output rd_cmd_t [NQ-1:0]    cmd
);
    logic [LOC_W-1:0]          col_lo, col_hi, row_lo, row_hi;
    logic [1:0]                hx, hy;
    logic [NQ-1:0][PRE_W-1:0]  pre;
    logic [PRE_W-1:0]          run;

    always_comb begin
        // local extent of the window inside this block
        col_lo = (wx0[XW-1:LOC_W] == bx) ? wx0[LOC_W-1:0] : '0;
        col_hi = (wx1[XW-1:LOC_W] == bx) ? wx1[LOC_W-1:0] : '1;
        row_lo = (wy0[YW-1:LOC_W] == by) ? wy0[LOC_W-1:0] : '0;
        row_hi = (wy1[YW-1:LOC_W] == by) ? wy1[LOC_W-1:0] : '1;
        hx[0]  = col_lo < split_x;
        hx[1]  = col_hi >= split_x;
        hy[0]  = row_lo < split_y;
        hy[1]  = row_hi >= split_y;
        run    = '0;
        for (int q = 0; q < NQ; q++) begin
            pre[q] = run;
            run    = run + PRE_W'(meta.sz[q]);
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_quad
        localparam int CH = q % 2;
        localparam int RH = q / 2;
        assign want[q]     = hx[CH] && hy[RH] && (meta.sz[q] != '0);
        assign cmd[q].addr = meta.ptr + (PTR_W'(pre[q]) << BURST_LG);
        assign cmd[q].len  = meta.sz[q];
    end
endmodule

// File: rtl/gt_fetch_agen.sv
module gt_fetch_agen
    import gt_pkg::*;
#(
    parameter int MAP_BW = 4,
    parameter int MAP_BH = 4,
    parameter int GROUPS = 3,
    localparam int XW    = $clog2(MAP_BW * 8),
    localparam int YW    = $clog2(MAP_BH * 8),
    localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int MAW   = $clog2(GROUPS * MAP_BH * MAP_BW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        split_x,
    input  logic [2:0]        split_y,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XW-1:0]     req_x0,
    input  logic [YW-1:0]     req_y0,
    input  logic [XW-1:0]     req_x1,
    input  logic [YW-1:0]     req_y1,
    input  logic [GW-1:0]     req_grp,
    output logic              req_err,
    output logic              meta_rd_en,
    output logic [MAW-1:0]    meta_rd_addr,
    input  logic [47:0]       meta_rd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [27:0]       cmd_addr,
    output logic [4:0]        cmd_len,
    output logic              win_done
);
    localparam int BXW = XW - LOC_W;
    localparam int BYW = YW - LOC_W;

    seq_st_e             st;
    logic [XW-1:0]       wx0, wx1;
    logic [YW-1:0]       wy0, wy1;
    logic [GW-1:0]       wgrp;
    logic [BXW-1:0]      bx;
    logic [BYW-1:0]      by;
    logic [1:0]          q;
    blk_meta_t           meta_q;
    rd_cmd_t             pend;
    logic                pend_v;
    logic                err_q;
    logic                legal;
    logic [NQ-1:0]       want;
    rd_cmd_t [NQ-1:0]    qcmd;
    logic                cand, step, last_blk;

    gt_req_check #(.XW(XW), .YW(YW), .GW(GW), .GROUPS(GROUPS)) u_check (
        .x0(req_x0), .y0(req_y0), .x1(req_x1), .y1(req_y1), .grp(req_grp),
        .split_x(split_x), .split_y(split_y), .legal(legal)
    );

    gt_quad_map #(.XW(XW), .YW(YW)) u_quad (
        .bx(bx), .by(by), .wx0(wx0), .wx1(wx1), .wy0(wy0), .wy1(wy1),
        .split_x(split_x), .split_y(split_y), .meta(meta_q),
        .want(want), .cmd(qcmd)
    );

    always_comb begin
        cand     = want[q];
        // a pending command leaves only once a successor exists or the window ends
        step     = (st == ST_SCAN) && (!(cand && pend_v) || cmd_ready);
        last_blk = (bx == wx1[XW-1:LOC_W]) && (by == wy1[YW-1:LOC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pend_v <= 1'b0;
            err_q  <= 1'b0;
            pend   <= '0;
            meta_q <= '0;
            q      <= '0;
            bx     <= '0;
            by     <= '0;
            wx0    <= '0;
            wx1    <= '0;
            wy0    <= '0;
            wy1    <= '0;
            wgrp   <= '0;
        end else begin
            err_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (legal) begin
                            wx0  <= req_x0;
                            wx1  <= req_x1;
                            wy0  <= req_y0;
                            wy1  <= req_y1;
                            wgrp <= req_grp;
                            bx   <= req_x0[XW-1:LOC_W];
                            by   <= req_y0[YW-1:LOC_W];
                            st   <= ST_META;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_META: st <= ST_LOAD;
                ST_LOAD: begin
                    meta_q <= blk_meta_t'(meta_rd_data);
                    q      <= '0;
                    st     <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (step) begin
                        if (cand) begin
                            pend   <= qcmd[q];
                            pend_v <= 1'b1;
                        end
                        q <= q + 1'b1;
                        if (q == 2'd3) begin
                            if (last_blk) begin
                                st <= ST_FLUSH;
                            end else begin
                                if (bx == wx1[XW-1:LOC_W]) begin
                                    bx <= wx0[XW-1:LOC_W];
                                    by <= by + 1'b1;
                                end else begin
                                    bx <= bx + 1'b1;
                                end
                                st <= ST_META;
                            end
                        end
                    end
                end
                ST_FLUSH: begin
                    if (!pend_v || cmd_ready) begin
                        pend_v <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign req_err      = err_q;
    assign meta_rd_en   = (st == ST_META);
    assign meta_rd_addr = MAW'((32'(wgrp) * 32'(MAP_BH) + 32'(by)) * 32'(MAP_BW) + 32'(bx));
    assign cmd_valid    = pend_v && (((st == ST_SCAN) && cand) || (st == ST_FLUSH));
    assign cmd_addr     = pend.addr;
    assign cmd_len      = pend.len;
    assign win_done     = (st == ST_FLUSH);
endmodule

// File: rtl/gt_fetch_agen_chk.sv
module gt_fetch_agen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        req_err,
    input logic        meta_rd_en,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [27:0] cmd_addr,
    input logic [4:0]  cmd_len,
    input logic        win_done
);
    // R10
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(win_done)));

    // R11
    no_cmd_at_read_chk: assert property (@(posedge clk) disable iff (rst)
        meta_rd_en |-> !cmd_valid);

    // R11
    no_cmd_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        meta_rd_en |=> !cmd_valid);

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len != 5'd0));

    // R9
    busy_while_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (req_ready && !cmd_valid && !meta_rd_en));

    // R7
    lone_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (win_done && !cmd_valid) |=> !win_done);
endmodule

bind gt_fetch_agen gt_fetch_agen_chk i_gt_fetch_agen_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .req_err(req_err),
    .meta_rd_en(meta_rd_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .win_done(win_done)
);

// File: tb/test_gt_fetch_agen.sv
module test_gt_fetch_agen;
    localparam int BW = 4, BH = 4, NG = 3;
    localparam int NBLK = BW * BH * NG;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  split_x = 3'd2, split_y = 3'd6;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_x0 = '0, req_y0 = '0, req_x1 = '0, req_y1 = '0;
    logic [1:0]  req_grp = '0;
    logic        req_err;
    logic        meta_rd_en;
    logic [5:0]  meta_rd_addr;
    logic [47:0] meta_rd_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [27:0] cmd_addr;
    logic [4:0]  cmd_len;
    logic        win_done;

    logic [47:0] mem [NBLK];
    logic [32:0] exp_q [$];
    int          exp_idx [$];
    int          nchk = 0, nerr = 0, nreads = 0;
    bit          active = 0, finished = 0, rand_ready = 0, ended = 0;
    bit          hold_p = 0;
    logic [33:0] held;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    gt_fetch_agen i_gt_fetch_agen (
        .clk(clk), .rst(rst), .split_x(split_x), .split_y(split_y),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_x0(req_x0), .req_y0(req_y0), .req_x1(req_x1), .req_y1(req_y1),
        .req_grp(req_grp), .req_err(req_err),
        .meta_rd_en(meta_rd_en), .meta_rd_addr(meta_rd_addr), .meta_rd_data(meta_rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .win_done(win_done)
    );

    // metadata memory model, one cycle latency
    always @(posedge clk) if (meta_rd_en) meta_rd_data <= mem[meta_rd_addr];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmd_ready = rand_ready ? lfsr[0] : 1'b1;
        end
    end

    // reference model of the command list
    task automatic build_expect(input int x0, input int y0, input int x1, input int y1, input int g);
        int sx, sy;
        sx = split_x;
        sy = split_y;
        exp_q.delete();
        exp_idx.delete();
        for (int br = y0 / 8; br <= y1 / 8; br++) begin
            for (int bc = x0 / 8; bc <= x1 / 8; bc++) begin
                int idx, run;
                logic [47:0] m;
                idx = (g * BH + br) * BW + bc;
                exp_idx.push_back(idx);
                m = mem[idx];
                run = 0;
                for (int q = 0; q < 4; q++) begin
                    int sz, clo, chi, rlo, rhi;
                    logic [27:0] a;
                    sz  = int'(m[q*5 +: 5]);
                    clo = bc * 8 + ((q % 2) ? sx : 0);
                    chi = bc * 8 + ((q % 2) ? 7 : sx - 1);
                    rlo = br * 8 + ((q / 2) ? sy : 0);
                    rhi = br * 8 + ((q / 2) ? 7 : sy - 1);
                    a = m[47:20] + 28'(run * 16);
                    if (sz != 0 && clo <= x1 && chi >= x0 && rlo <= y1 && rhi >= y0)
                        exp_q.push_back({a, 5'(sz)});
                    run += sz;
                end
            end
        end
    endtask

    // output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (hold_p)  // R10
                chk(cmd_valid && {cmd_addr, cmd_len, win_done} == held, "R10 hold",
                    {cmd_valid, cmd_addr, cmd_len, win_done}, {1'b1, held});
            hold_p = cmd_valid && !cmd_ready;
            held   = {cmd_addr, cmd_len, win_done};
            if (meta_rd_en) begin
                nreads++;
                chk(exp_idx.size() > 0 && meta_rd_addr == 6'(exp_idx[0]), "R2 meta index",
                    meta_rd_addr, exp_idx.size() > 0 ? exp_idx[0] : -1);
                chk(!cmd_valid, "R11 no command during read", cmd_valid, 0);
                if (exp_idx.size() > 0) void'(exp_idx.pop_front());
            end
            if (cmd_valid) begin
                chk(active, "R8 command only for legal window", active, 1);
                chk(!req_ready, "R9 busy", req_ready, 0);
            end
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 extra command", {cmd_addr, cmd_len}, 0);
                end else begin
                    // R3 R5 R6
                    chk({cmd_addr, cmd_len} == exp_q[0], "R5 R6 command", {cmd_addr, cmd_len}, exp_q[0]);
                    chk(win_done == (exp_q.size() == 1), "R7 done with final", win_done, exp_q.size() == 1);
                    void'(exp_q.pop_front());
                end
                if (win_done) finished = 1;
            end else if (win_done && !cmd_valid) begin
                chk(exp_q.size() == 0, "R7 lone done", exp_q.size(), 0);
                finished = 1;
            end
        end
    end

    task automatic run_window(input int x0, input int y0, input int x1, input int y1, input int g, input bit bad);
        int r0;
        if (!bad) build_expect(x0, y0, x1, y1, g);
        else begin
            exp_q.delete();
            exp_idx.delete();
        end
        finished = 0;
        active   = !bad;
        @(negedge clk);
        req_x0 = 5'(x0); req_y0 = 5'(y0); req_x1 = 5'(x1); req_y1 = 5'(y1); req_grp = 2'(g);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        r0 = nreads;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk(req_err == 1'b1, "R8 error pulse", req_err, 1);
            chk(req_ready == 1'b1, "R8 stays ready", req_ready, 1);
            repeat (3) @(negedge clk);
            chk(req_err == 1'b0, "R8 pulse is one cycle", req_err, 0);
            chk(nreads == r0 && !cmd_valid, "R8 no reads", nreads - r0, 0);
        end else begin
            chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 1);
            wait (finished);
            @(negedge clk);
            chk(exp_q.size() == 0, "R3 all commands seen", exp_q.size(), 0);
            chk(exp_idx.size() == 0, "R2 all blocks read", exp_idx.size(), 0);
            chk(req_ready == 1'b1, "R9 ready after end", req_ready, 1);
        end
        active = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < NBLK; i++) begin
            logic [47:0] m;
            m[47:20] = 28'(i * 700 + 4096);
            for (int q = 0; q < 4; q++) begin
                int s;
                s = (i * 11 + q * 7 + 3) % 40;
                m[q*5 +: 5] = (s > 31) ? 5'd0 : 5'(s);
            end
            mem[i] = m;
        end
        mem[5] = {28'h0123456, 20'd0};                       // all-zero block (g0, row1, col1)
        mem[6] = {28'hFFFFFF0, 5'd5, 5'd4, 5'd0, 5'd3};      // TR empty, address wraps
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready && !cmd_valid && !win_done && !req_err && !meta_rd_en, "R1 reset state",
            {req_ready, cmd_valid, win_done, req_err, meta_rd_en}, 5'b10000);

        run_window(0, 0, 31, 31, 0, 0);      // R3 R6 whole map
        run_window(2, 6, 9, 21, 1, 0);       // R3 split-aligned edges
        run_window(0, 0, 1, 5, 2, 0);        // R3 single top-left subtensor
        run_window(16, 8, 23, 15, 0, 0);     // R4 R5 empty TR, wrapped address
        run_window(0, 8, 15, 15, 0, 0);      // R7 trailing empty block
        run_window(8, 8, 15, 15, 0, 0);      // R7 lone done
        run_window(3, 0, 15, 15, 0, 1);      // R8 misaligned start
        run_window(16, 0, 7, 15, 0, 1);      // R8 reversed
        run_window(0, 0, 7, 7, 3, 1);        // R8 group out of range
        run_window(0, 0, 7, 4, 0, 1);        // R8 misaligned end
        rand_ready = 1;
        split_x = 3'd5; split_y = 3'd3;
        run_window(5, 3, 20, 26, 2, 0);      // R10 backpressure
        split_x = 3'd1; split_y = 3'd7;
        run_window(0, 0, 31, 31, 1, 0);
        run_window(1, 7, 8, 14, 2, 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule